// File: doc/BRIEF.md
# Track Index Locator and Navigator

This block keeps a table of track start sector addresses and moves playback from one track to the next. Each table entry is a 32-bit sector address, and the first all-zero entry ends the list. The block does not count tracks as they play. When a skip is requested, it scans the table from entry 0 and compares each entry with the live playback sector address. From that scan it works out which track is playing, picks the track after or before it, and hands the start address of that track to the sector reader.

Three raw push buttons drive the block: previous, pause and next. Each button passes through a two-flop synchroniser. A button acts once per press, and a shared lockout timer masks all button sampling for a set time after any action. Pause toggles a flag. Previous and next are refused while paused. Every track change raises a one-cycle resync request toward the decoder. One cycle later comes the load strobe that carries the new address. Filling the table is done by an external writer through a simple write port, and the block does not read any sectors itself.

Top module: `trk_nav`

## Requirements
- R1: The table holds DEPTH (default 1024) entries of 32 bits, indexed by a 10-bit index. A write with `tbl_we` high stores `tbl_wdata` at `tbl_widx`, and later scans use the stored value. All entries reset to zero.
- R2: A scan reads one entry per clock, starting at index 0. It moves past entry j only while that entry is non-zero, the snapshot address is strictly greater than the entry, and j is below DEPTH-1. The first entry that fails this test ends the scan.
- R3: At the ending entry j, the current track is j when the entry is non-zero and the address is equal to or greater than it. Otherwise the current track is j-1 modulo DEPTH, so an address below entry 0 gives DEPTH-1.
- R4: The next button selects current+1 and the previous button selects current-1, both modulo DEPTH. `trk_idx` returns the selected index and `load_lba` returns its entry.
- R5: If the selected entry is zero, `trk_idx` is 0 and `load_lba` is entry 0.
- R6: The pause button toggles `paused`. A previous or next press sampled while paused is consumed and has no effect. Reset clears `paused`.
- R7: A button that is still held after acting does not act again until it has been sampled released.
- R8: After any button action, no button is sampled (pressed or released) for LOCK_CYC clocks.
- R9: Every track change drives `resync` high for exactly one cycle. `load_stb` is high for the one cycle right after it.
- R10: `busy` is high from the clock edge that accepts a previous or next action until the cycle of `load_stb`, and it falls on the edge after that. No button is sampled while busy.
- R11: If several armed buttons are seen pressed in the same sample, only one acts, with previous first, then pause, then next. The others stay armed.
- R12: A press that is applied before clock edge 1 shows its effect after edge 3 (two synchroniser stages, then the action register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_widx | input | 10 | Table write index |
| tbl_wdata | input | 32 | Table write data (track start sector) |
| cur_lba | input | 32 | Live playback sector address |
| btn_prev | input | 1 | Raw previous button, high when pressed |
| btn_pause | input | 1 | Raw pause button, high when pressed |
| btn_next | input | 1 | Raw next button, high when pressed |
| busy | output | 1 | Scan and load in progress |
| paused | output | 1 | Pause flag |
| resync | output | 1 | One-cycle decoder resync request |
| load_stb | output | 1 | One-cycle strobe: `load_lba` and `trk_idx` are valid |
| load_lba | output | 32 | Start sector of the selected track |
| trk_idx | output | 10 | Index of the selected track |

## Verification
Counting from the first edge after a button is driven, `paused` changes after edge 3. When a skip's scan ends at entry j, `resync` rises after edge 4+j, `load_stb` follows after edge 5+j, and `busy` falls one edge after that. The bench drives inputs on falling edges and samples outputs on falling edges. It counts those edges until the strobe appears and compares the count with 5+j, where j comes from its own model of the scan. On the sample before the strobe it expects `resync` high. Refused presses and lockout presses are judged by watching `paused` and a strobe counter over a window longer than any latency.

// File: rtl/trk_nav_pkg.sv
package trk_nav_pkg;
  localparam int LBA_W = 32;

  typedef enum logic [1:0] {REL_LT, REL_EQ, REL_GT} rel_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_SEL, ST_LOAD} nav_st_e;

  // ordering of the live address against one table entry
  function automatic rel_e lba_rel(input logic [LBA_W-1:0] live,
                                   input logic [LBA_W-1:0] ent);
    if (live > ent)       return REL_GT;
    else if (live == ent) return REL_EQ;
    else                  return REL_LT;
  endfunction

  // scan stops at this entry
  function automatic logic scan_stop(input logic [LBA_W-1:0] ent,
                                     input rel_e r, input logic at_last);
    return (ent == '0) || (r != REL_GT) || at_last;
  endfunction

  // current track is the stopping entry itself (else the one before)
  function automatic logic scan_hit(input logic [LBA_W-1:0] ent,
                                    input rel_e r);
    return (ent != '0) && (r != REL_LT);
  endfunction
endpackage

// File: rtl/trk_table.sv
module trk_table #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] head_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data   = mem[rd_idx];
  assign head_data = mem[0];
endmodule

// File: rtl/trk_btn_ctl.sv
module trk_btn_ctl #(
  parameter int LOCK_CYC = 50000,
  parameter int NBTN     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_prev,
  input  logic raw_pause,
  input  logic raw_next,
  input  logic busy,
  output logic paused,
  output logic go_prev,
  output logic go_next
);
  localparam int LW = $clog2(LOCK_CYC + 1);
  localparam int B_PREV = 0, B_PAUSE = 1, B_NEXT = 2;

  logic [NBTN-1:0] sync1_q, sync2_q, arm_q, pressed, consumed;
  logic [LW-1:0]   lock_q;
  logic            paused_q, samp_en, act_pause, act_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= {raw_next, raw_pause, raw_prev};
      sync2_q <= sync1_q;
    end
  end

  assign samp_en = (lock_q == '0) && !busy;
  assign pressed = sync2_q & arm_q & {NBTN{samp_en}};

  // priority: previous, then pause, then next
  assign go_prev   = pressed[B_PREV] && !paused_q;
  assign act_pause = pressed[B_PAUSE] && !go_prev;
  assign go_next   = pressed[B_NEXT] && !paused_q && !go_prev && !act_pause;
  assign act_any   = go_prev || act_pause || go_next;

  assign consumed[B_PREV]  = go_prev || (pressed[B_PREV] && paused_q);
  assign consumed[B_PAUSE] = act_pause;
  assign consumed[B_NEXT]  = go_next || (pressed[B_NEXT] && paused_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= '1;
    end else if (samp_en) begin
      for (int b = 0; b < NBTN; b++) begin
        if (!sync2_q[b])      arm_q[b] <= 1'b1;
        else if (consumed[b]) arm_q[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q   <= '0;
      paused_q <= 1'b0;
    end else begin
      if (act_any)           lock_q <= LW'(LOCK_CYC);
      else if (lock_q != '0) lock_q <= lock_q - 1'b1;
      if (act_pause) paused_q <= !paused_q;
    end
  end

  assign paused = paused_q;

  assert_one_action_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_prev, act_pause, go_next}));

  assert_lockout_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != '0) |-> !(go_prev || act_pause || go_next));

  assert_pause_only_by_button_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_q != $past(paused_q)) |-> $past(act_pause));

  assert_no_skip_paused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    paused_q |-> !(go_prev || go_next));
endmodule

// File: rtl/trk_search.sv
module trk_search
  import trk_nav_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_prev,
  input  logic             go_next,
  input  logic [LBA_W-1:0] cur_lba,
  output logic [AW-1:0]    rd_idx,
  input  logic [LBA_W-1:0] rd_data,
  input  logic [LBA_W-1:0] head_data,
  output logic             busy,
  output logic             resync,
  output logic             load_stb,
  output logic [LBA_W-1:0] load_lba,
  output logic [AW-1:0]    trk_idx
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] ONE  = AW'(1);

  nav_st_e          st_q;
  logic [AW-1:0]    idx_q, tgt_q, trk_q, cur_trk;
  logic [LBA_W-1:0] snap_q, lba_q;
  logic             fwd_q, stop_now;
  rel_e             rel;

  assign rd_idx   = (st_q == ST_SEL) ? tgt_q : idx_q;
  assign rel      = lba_rel(snap_q, rd_data);
  assign stop_now = scan_stop(rd_data, rel, idx_q == LAST);
  assign cur_trk  = scan_hit(rd_data, rel) ? idx_q : idx_q - ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      tgt_q  <= '0;
      trk_q  <= '0;
      snap_q <= '0;
      lba_q  <= '0;
      fwd_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_prev || go_next) begin
          st_q   <= ST_SCAN;
          idx_q  <= '0;
          snap_q <= cur_lba;
          fwd_q  <= go_next;
        end
        ST_SCAN: begin
          if (stop_now) begin
            st_q  <= ST_SEL;
            tgt_q <= fwd_q ? cur_trk + ONE : cur_trk - ONE;
          end else begin
            idx_q <= idx_q + ONE;
          end
        end
        ST_SEL: begin
          st_q <= ST_LOAD;
          if (rd_data == '0) begin
            trk_q <= '0;
            lba_q <= head_data;
          end else begin
            trk_q <= tgt_q;
            lba_q <= rd_data;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign resync   = (st_q == ST_SEL);
  assign load_stb = (st_q == ST_LOAD);
  assign load_lba = lba_q;
  assign trk_idx  = trk_q;

  assert_resync_before_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(resync));

  assert_single_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);

  assert_no_start_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prev || go_next) |-> !busy);

  assert_empty_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && trk_idx != '0) |-> (load_lba != '0));

  assert_scan_in_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN && $past(st_q) == ST_SCAN) |-> (idx_q == $past(idx_q) + ONE));
endmodule

// File: rtl/trk_nav.sv
module trk_nav #(
  parameter int DEPTH    = 1024,
  parameter int AW       = $clog2(DEPTH),
  parameter int LOCK_CYC = 50000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_widx,
  input  logic [31:0]   tbl_wdata,
  input  logic [31:0]   cur_lba,
  input  logic          btn_prev,
  input  logic          btn_pause,
  input  logic          btn_next,
  output logic          busy,
  output logic          paused,
  output logic          resync,
  output logic          load_stb,
  output logic [31:0]   load_lba,
  output logic [AW-1:0] trk_idx
);
  logic          go_prev, go_next;
  logic [AW-1:0] rd_idx;
  logic [31:0]   rd_data, head_data;

  trk_btn_ctl #(.LOCK_CYC(LOCK_CYC)) u_btn (
    .clk(clk), .rst_n(rst_n),
    .raw_prev(btn_prev), .raw_pause(btn_pause), .raw_next(btn_next),
    .busy(busy), .paused(paused), .go_prev(go_prev), .go_next(go_next)
  );

  trk_table #(.DEPTH(DEPTH), .AW(AW), .DW(32)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(tbl_widx), .wr_data(tbl_wdata),
    .rd_idx(rd_idx), .rd_data(rd_data), .head_data(head_data)
  );

  trk_search #(.DEPTH(DEPTH), .AW(AW)) u_srch (
    .clk(clk), .rst_n(rst_n),
    .go_prev(go_prev), .go_next(go_next), .cur_lba(cur_lba),
    .rd_idx(rd_idx), .rd_data(rd_data), .head_data(head_data),
    .busy(busy), .resync(resync), .load_stb(load_stb),
    .load_lba(load_lba), .trk_idx(trk_idx)
  );
endmodule

// File: tb/trk_nav_tb_top.sv
module trk_nav_tb_top;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;
  localparam int LOCK  = 40;
  localparam int NVEC  = 8;

  typedef struct packed {
    logic [31:0]   lba;
    logic          fwd;
    logic [AW-1:0] exp_idx;
    logic [31:0]   exp_lba;
    logic [10:0]   stop_j;
  } vec_t;

  // table: entry k = 1000*(k+1) for k<5, rest zero
  localparam vec_t VECS [NVEC] = '{
    '{32'd1500, 1'b1, 10'd1,   32'd2000, 11'd1},
    '{32'd2000, 1'b1, 10'd2,   32'd3000, 11'd1},
    '{32'd4500, 1'b0, 10'd2,   32'd3000, 11'd4},
    '{32'd9000, 1'b1, 10'd0,   32'd1000, 11'd5},
    '{32'd500,  1'b0, 10'd0,   32'd1000, 11'd0},
    '{32'd500,  1'b1, 10'd0,   32'd1000, 11'd0},
    '{32'd1000, 1'b0, 10'd0,   32'd1000, 11'd0},
    '{32'd5000, 1'b0, 10'd3,   32'd4000, 11'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [AW-1:0] tbl_widx = '0;
  logic [31:0] tbl_wdata = '0, cur_lba = '0;
  logic btn_prev = 1'b0, btn_pause = 1'b0, btn_next = 1'b0;
  logic busy, paused, resync, load_stb;
  logic [31:0] load_lba;
  logic [AW-1:0] trk_idx;

  int n_chk = 0, n_bad = 0, stb_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trk_nav #(.DEPTH(DEPTH), .AW(AW), .LOCK_CYC(LOCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_widx(tbl_widx),
    .tbl_wdata(tbl_wdata), .cur_lba(cur_lba), .btn_prev(btn_prev),
    .btn_pause(btn_pause), .btn_next(btn_next), .busy(busy), .paused(paused),
    .resync(resync), .load_stb(load_stb), .load_lba(load_lba), .trk_idx(trk_idx)
  );

  always @(negedge clk) if (load_stb) stb_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_entry(input int i, input logic [31:0] v);
    tbl_we = 1'b1; tbl_widx = AW'(i); tbl_wdata = v;
    step(1);
    tbl_we = 1'b0;
  endtask

  // one skip: returns after load strobe and release
  task automatic skip(input logic [31:0] lba, input logic fwd, input logic [AW-1:0] eidx,
                      input logic [31:0] elba, input int j, input string tag);
    int n = 0;
    bit got = 1'b0, prev_rs = 1'b0;
    cur_lba = lba;
    if (fwd) btn_next = 1'b1; else btn_prev = 1'b1;
    while (!got && n < 4000) begin
      step(1); n++;
      if (load_stb) got = 1'b1; else prev_rs = resync;
    end
    chk({tag, " R2 strobe edge count"}, n, 5 + j);
    chk({tag, " R9 resync before strobe"}, {31'd0, prev_rs}, 1);
    chk({tag, " R3 R4 track index"}, {22'd0, trk_idx}, {22'd0, eidx});
    chk({tag, " R4 R5 loaded address"}, load_lba, elba);
    chk({tag, " R10 busy at strobe"}, {31'd0, busy}, 1);
    btn_next = 1'b0; btn_prev = 1'b0;
    step(1);
    chk({tag, " R10 busy falls"}, {31'd0, busy}, 0);
    step(LOCK + 20);
  endtask

  task automatic tap_pause();
    btn_pause = 1'b1; step(4); btn_pause = 1'b0; step(LOCK + 20);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int s0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R6 reset paused", {31'd0, paused}, 0);
    chk("R10 reset busy", {31'd0, busy}, 0);
    chk("R9 reset strobe/resync", {30'd0, load_stb, resync}, 0);

    for (int k = 0; k < 5; k++) wr_entry(k, 32'(1000 * (k + 1)));

    for (int i = 0; i < NVEC; i++)
      skip(VECS[i].lba, VECS[i].fwd, VECS[i].exp_idx, VECS[i].exp_lba,
           int'(VECS[i].stop_j), $sformatf("R1 vec%0d", i));

    // R12 latency, R6 toggle
    btn_pause = 1'b1;
    step(2);
    chk("R12 paused not yet after edge 2", {31'd0, paused}, 0);
    step(1);
    chk("R12 R6 paused after edge 3", {31'd0, paused}, 1);
    btn_pause = 1'b0;
    step(LOCK + 20);

    // R6: skip refused while paused
    s0 = stb_cnt;
    cur_lba = 32'd1500;
    btn_next = 1'b1; step(60); btn_next = 1'b0;
    chk("R6 next ignored while paused", stb_cnt - s0, 0);
    chk("R6 no busy while paused", {31'd0, busy}, 0);
    step(LOCK + 20);

    // R8: release and re-press inside lockout never seen
    btn_pause = 1'b1; step(3);
    chk("R8 pause cleared", {31'd0, paused}, 0);
    step(2); btn_pause = 1'b0; step(5);
    btn_pause = 1'b1; step(20); btn_pause = 1'b0;
    step(60);
    chk("R8 no toggle from press within lockout", {31'd0, paused}, 0);

    // R7: long hold acts once
    btn_pause = 1'b1; step(200); btn_pause = 1'b0;
    chk("R7 held button toggles once", {31'd0, paused}, 1);
    step(LOCK + 20);
    tap_pause();
    chk("R7 new press toggles back", {31'd0, paused}, 0);

    // R11: previous and pause together
    s0 = stb_cnt;
    cur_lba = 32'd1500;
    btn_prev = 1'b1; btn_pause = 1'b1;
    step(12);
    chk("R11 previous wins", stb_cnt - s0, 1);
    chk("R11 pause held back", {31'd0, paused}, 0);
    chk("R11 R5 previous from track 0 wraps", load_lba, 32'd1000);
    btn_prev = 1'b0;
    step(LOCK + 20);
    chk("R11 pause stays armed and acts", {31'd0, paused}, 1);
    btn_pause = 1'b0;
    step(LOCK + 20);
    tap_pause();
    chk("R11 unpaused", {31'd0, paused}, 0);

    // R1 rewrite: entry 2 emptied, next from track 1 wraps to 0
    wr_entry(2, 32'd0);
    skip(32'd2000, 1'b1, 10'd0, 32'd1000, 1, "R1 R5 rewritten entry");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule